// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Prescaler

This block holds an 8-bit up-counter and a watchdog timer that share a single programmable prescaler. The counter advances from one of two sources. The first is an internal instruction-rate tick, which is the core clock divided by 2 or by 4. The second is an external count pin, which passes through a two-stage synchronizer and an edge detector, and either its rising or its falling edge can be selected. A single assignment bit places the prescaler in front of the counter or in front of the watchdog. Whichever of the two is not assigned runs unscaled.

Software sees two byte-wide locations: the count value at address 0 and a control byte at address 1. The counter sets a sticky overflow flag when it wraps from all ones to zero. The watchdog counts a free-running tick from an external time base. When it reaches its limit, it emits a one-cycle reset pulse. Software can enable the watchdog, disable it, or restart it with a clear strobe.

Top module: `tmr_wdt_top`

## Requirements
- R1: While reset is asserted, the count reads 0, the control byte reads 0 and `wdt_rst` is low.
- R2: A write to address 0 loads the count. A write to address 1 loads the control byte, whose fields are: bits 2:0 ratio, bit 3 prescaler assignment (1 = watchdog), bit 4 source (1 = external pin), bit 5 edge (1 = falling) and bit 7 internal divide (1 = divide by 4). `reg_rdata` returns the location named by `reg_addr`.
- R3: A count step from 8'hFF to 8'h00 sets `ovf_flag`, which is also read back as control bit 6. The flag stays set until a control write with bit 6 = 0. A control write with bit 6 = 1 does not change the flag.
- R4: In external mode, only the selected edge of `ext_cnt_in` advances the count. The opposite edge has no effect.
- R5: A new level on `ext_cnt_in` that is first sampled at clock edge k changes the count at clock edge k+2, and not before.
- R6: With the internal source and the counter unscaled, the count advances once every 2 clocks when bit 7 = 0 and once every 4 clocks when bit 7 = 1.
- R7: With the prescaler assigned to the counter, the count advances once per 2^(ratio+1) source events.
- R8: With the prescaler assigned to the watchdog, the counter advances on every source event, and the watchdog advances once per 2^ratio ticks.
- R9: A write to the count register clears the prescaler.
- R10: When the watchdog is enabled, `wdt_rst` pulses high for exactly one cycle after WDT_LIMIT watchdog steps without a clear. The watchdog count then restarts.
- R11: `wdt_clr` restarts the watchdog count. When the prescaler is assigned to the watchdog, `wdt_clr` also clears the prescaler.
- R12: While `wdt_en` is low, `wdt_rst` stays low and the watchdog count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Location select: 0 = count, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected location |
| ext_cnt_in | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog time-base tick, one cycle per tick |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Watchdog restart strobe |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| wdt_rst | output | 1 | One-cycle watchdog time-out pulse |

## Verification
Most of the prescaler state is hidden. A prescaler that is not cleared on a count write, or on a watchdog clear, shows up at the ports as a count or a time-out that comes one source event early. Each such case is therefore checked with an exact number of events rather than a tolerance. A wrong synchronizer depth shows up as a count change one clock off from edge k+2. A wrong divide or tap choice shows up as a wrong count difference over a fixed window of 40 or 160 clocks. A watchdog count that is not held or restarted shows up as a missing time-out pulse, or one at the wrong tick, within at most twice WDT_LIMIT ticks.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;

    localparam int DATA_W  = 8;
    localparam int RATIO_W = 3;

    localparam logic ADDR_COUNT = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    // control byte bit positions
    localparam int B_ASSIGN = 3;
    localparam int B_SRC    = 4;
    localparam int B_EDGE   = 5;
    localparam int B_OVF    = 6;
    localparam int B_DIV4   = 7;

    typedef struct packed {
        logic               div4;
        logic               fall_edge;
        logic               src_ext;
        logic               pre_to_wdt;
        logic [RATIO_W-1:0] ratio;
    } ctrl_t;

endpackage

// File: rtl/tw_tick_src.sv
module tw_tick_src (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic src_ext,
    input  logic fall_edge,
    input  logic div4,
    output logic step
);
    typedef struct packed {
        logic       s1;
        logic       s2;
        logic       s3;
        logic [1:0] div;
    } src_st_t;

    src_st_t st_d, st_q;
    logic int_tick, ext_rise, ext_fall;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = ext_pin;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        st_d.div = st_q.div + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_tick = div4 ? (st_q.div == 2'b11) : st_q.div[0];
    assign ext_rise = st_q.s2 & ~st_q.s3;
    assign ext_fall = ~st_q.s2 & st_q.s3;
    assign step     = src_ext ? (fall_edge ? ext_fall : ext_rise) : int_tick;

endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               pulse_in,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               to_wdt,
    output logic               pulse_out
);
    localparam int PRE_W = 1 << RATIO_W;
    localparam int EXP_W = RATIO_W + 1;

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W:0]   tap_hit;
    logic [EXP_W-1:0] tap_sel;

    assign tap_hit[0] = 1'b1;
    for (genvar i = 1; i <= PRE_W; i++) begin : g_tap
        assign tap_hit[i] = &cnt_q[i-1:0];
    end

    // counter side runs one tap coarser than the watchdog side
    assign tap_sel   = EXP_W'(ratio) + EXP_W'(!to_wdt);
    assign pulse_out = pulse_in & ~clr & tap_hit[tap_sel];

    always_comb begin
        cnt_d = cnt_q;
        if (clr)           cnt_d = '0;
        else if (pulse_in) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
    parameter int LIMIT = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic step,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (!en || clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.fire;

endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top
    import tmr_wdt_pkg::*;
#(
    parameter int WDT_LIMIT = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_cnt_in,
    input  logic              wdt_tick,
    input  logic              wdt_en,
    input  logic              wdt_clr,
    output logic              ovf_flag,
    output logic              wdt_rst
);
    typedef struct packed {
        ctrl_t             ctl;
        logic [DATA_W-1:0] cnt;
        logic              ovf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic cnt_wr, ctl_wr;
    logic src_step, pre_in, pre_out, pre_clr, tmr_step, wdt_step;
    logic [DATA_W-1:0] cnt_q;

    assign cnt_wr = reg_wr && (reg_addr == ADDR_COUNT);
    assign ctl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign cnt_q  = st_q.cnt;

    tw_tick_src u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_cnt_in),
        .src_ext   (st_q.ctl.src_ext),
        .fall_edge (st_q.ctl.fall_edge),
        .div4      (st_q.ctl.div4),
        .step      (src_step)
    );

    assign pre_in  = st_q.ctl.pre_to_wdt ? wdt_tick : src_step;
    assign pre_clr = cnt_wr | (wdt_clr & st_q.ctl.pre_to_wdt);

    tw_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pre_clr),
        .pulse_in  (pre_in),
        .ratio     (st_q.ctl.ratio),
        .to_wdt    (st_q.ctl.pre_to_wdt),
        .pulse_out (pre_out)
    );

    assign tmr_step = st_q.ctl.pre_to_wdt ? src_step : pre_out;
    assign wdt_step = st_q.ctl.pre_to_wdt ? pre_out  : wdt_tick;

    tw_wdog #(.LIMIT(WDT_LIMIT)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (wdt_en),
        .clr    (wdt_clr),
        .step   (wdt_step),
        .expire (wdt_rst)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl.ratio      = reg_wdata[RATIO_W-1:0];
            st_d.ctl.pre_to_wdt = reg_wdata[B_ASSIGN];
            st_d.ctl.src_ext    = reg_wdata[B_SRC];
            st_d.ctl.fall_edge  = reg_wdata[B_EDGE];
            st_d.ctl.div4       = reg_wdata[B_DIV4];
            if (!reg_wdata[B_OVF]) st_d.ovf = 1'b0;
        end
        if (cnt_wr) begin
            st_d.cnt = reg_wdata;
        end else if (tmr_step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (reg_addr == ADDR_COUNT) begin
            reg_rdata = st_q.cnt;
        end else begin
            reg_rdata                = '0;
            reg_rdata[RATIO_W-1:0]   = st_q.ctl.ratio;
            reg_rdata[B_ASSIGN]      = st_q.ctl.pre_to_wdt;
            reg_rdata[B_SRC]         = st_q.ctl.src_ext;
            reg_rdata[B_EDGE]        = st_q.ctl.fall_edge;
            reg_rdata[B_OVF]         = st_q.ovf;
            reg_rdata[B_DIV4]        = st_q.ctl.div4;
        end
    end

    assign ovf_flag = st_q.ovf;

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          ovf_flag,
    input logic          wdt_en,
    input logic          wdt_clr,
    input logic          wdt_rst,
    input logic [DW-1:0] cnt,
    input logic          step
);
    p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 1'b0) |=> (cnt == $past(reg_wdata)));

    p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !(reg_wr && reg_addr == 1'b0)) |=> $stable(cnt));

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(reg_wr && reg_addr == 1'b0)) |=> (cnt == DW'($past(cnt) + 1'b1)));

    p_overflow_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && step && !(reg_wr && reg_addr == 1'b0)) |=> (ovf_flag && cnt == '0));

    p_overflow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(reg_wr && reg_addr == 1'b1 && !reg_wdata[6])) |=> ovf_flag);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    p_clear_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_rst);

    p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> !wdt_rst);

endmodule

bind tmr_wdt_top tw_checker #(.DW(tmr_wdt_pkg::DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ovf_flag  (ovf_flag),
    .wdt_en    (wdt_en),
    .wdt_clr   (wdt_clr),
    .wdt_rst   (wdt_rst),
    .cnt       (cnt_q),
    .step      (tmr_step)
);

// File: tb/tmr_wdt_top_tb_top.sv
module tmr_wdt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ext_cnt_in = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_en = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       ovf_flag;
    logic       wdt_rst;

    int checks = 0;
    int fails  = 0;
    int rst_hi = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_wdt_top #(.WDT_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_cnt_in(ext_cnt_in),
        .wdt_tick(wdt_tick), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
        .ovf_flag(ovf_flag), .wdt_rst(wdt_rst)
    );

    always @(posedge clk) if (rst_n && wdt_rst) rst_hi++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_cnt_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_cnt_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) wdt_tick = 1'b1;
            @(negedge clk) wdt_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_wdt();
        @(negedge clk) wdt_clr = 1'b1;
        @(negedge clk) wdt_clr = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        rd(1'b0, v); chk("R1 count", v, 0);
        rd(1'b1, v); chk("R1 ctrl", v, 0);
        chk("R1 wdt_rst", int'(wdt_rst), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_regs();
        int v;
        wr(1'b1, 8'h38);
        wr(1'b0, 8'h5A);
        rd(1'b0, v); chk("R2 count readback", v, 'h5A);
        rd(1'b1, v); chk("R2 ctrl readback", v, 'h38);
        wr(1'b1, 8'h78);
        rd(1'b1, v); chk("R3 flag not set by write", v, 'h38);
    endtask

    task automatic t_edges();
        int v;
        wr(1'b1, 8'h18);
        wr(1'b0, 8'h00);
        pulse_ext(5);
        rd(1'b0, v); chk("R4 rising edges", v, 5);
        wr(1'b1, 8'h38);
        wr(1'b0, 8'h00);
        pulse_ext(3);
        rd(1'b0, v); chk("R4 falling edges", v, 3);
        @(negedge clk) ext_cnt_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(1'b0, v); chk("R4 rising ignored", v, 3);
        ext_cnt_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(1'b0, v); chk("R4 falling counted", v, 4);
    endtask

    task automatic t_latency();
        wr(1'b1, 8'h18);
        wr(1'b0, 8'h00);
        @(negedge clk) reg_addr = 1'b0; ext_cnt_in = 1'b1;
        @(posedge clk);
        @(posedge clk); #1 chk("R5 no change at k+1", int'(reg_rdata), 0);
        @(posedge clk); #1 chk("R5 change at k+2", int'(reg_rdata), 1);
        @(negedge clk) ext_cnt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_internal();
        int a, b;
        wr(1'b1, 8'h08);
        rd(1'b0, a); repeat (39) @(negedge clk); rd(1'b0, b);
        chk("R6 divide by 2", (b - a) & 255, 20);
        wr(1'b1, 8'h88);
        rd(1'b0, a); repeat (39) @(negedge clk); rd(1'b0, b);
        chk("R6 divide by 4", (b - a) & 255, 10);
    endtask

    task automatic t_presc_timer();
        int a, b, v;
        wr(1'b1, 8'h02);
        rd(1'b0, a); repeat (159) @(negedge clk); rd(1'b0, b);
        chk("R7 ratio 1:8 internal", (b - a) & 255, 10);
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h00);
        pulse_ext(1);
        rd(1'b0, v); chk("R7 half step held", v, 0);
        wr(1'b0, 8'h00);
        pulse_ext(1);
        rd(1'b0, v); chk("R9 prescaler cleared by write", v, 0);
        pulse_ext(1);
        rd(1'b0, v); chk("R7 second event counts", v, 1);
        pulse_ext(6);
        rd(1'b0, v); chk("R7 ratio 1:2 external", v, 4);
    endtask

    task automatic t_overflow();
        int v;
        wr(1'b1, 8'h18);
        wr(1'b0, 8'hFE);
        pulse_ext(1);
        rd(1'b0, v); chk("R3 count at FF", v, 'hFF);
        chk("R3 flag before wrap", int'(ovf_flag), 0);
        pulse_ext(1);
        rd(1'b0, v); chk("R3 wrap to zero", v, 0);
        rd(1'b1, v); chk("R3 flag bit6 set", (v >> 6) & 1, 1);
        pulse_ext(2);
        chk("R3 flag sticky", int'(ovf_flag), 1);
        wr(1'b1, 8'h58);
        chk("R3 write 1 keeps flag", int'(ovf_flag), 1);
        wr(1'b1, 8'h18);
        chk("R3 write 0 clears flag", int'(ovf_flag), 0);
    endtask

    task automatic t_wdt_basic();
        int base;
        wr(1'b1, 8'h00);
        wdt_en = 1'b1;
        clr_wdt();
        base = rst_hi;
        ticks(LIMIT - 1);
        chk("R10 no pulse before limit", rst_hi - base, 0);
        ticks(1);
        chk("R10 one single-cycle pulse", rst_hi - base, 1);
        ticks(LIMIT);
        chk("R10 restart after time-out", rst_hi - base, 2);
    endtask

    task automatic t_wdt_presc();
        int a, b, base;
        wr(1'b1, 8'h09);
        rd(1'b0, a); repeat (39) @(negedge clk); rd(1'b0, b);
        chk("R8 counter unscaled", (b - a) & 255, 20);
        clr_wdt();
        base = rst_hi;
        ticks(2 * LIMIT - 1);
        chk("R8 wdt 1:2 before limit", rst_hi - base, 0);
        ticks(1);
        chk("R8 wdt 1:2 at limit", rst_hi - base, 1);
        ticks(1);
        clr_wdt();
        ticks(2 * LIMIT - 1);
        chk("R11 clear resets prescaler", rst_hi - base, 1);
        ticks(1);
        chk("R11 pulse after clear", rst_hi - base, 2);
    endtask

    task automatic t_wdt_clear_off();
        int base;
        wr(1'b1, 8'h00);
        clr_wdt();
        base = rst_hi;
        ticks(LIMIT - 1);
        clr_wdt();
        ticks(LIMIT - 1);
        chk("R11 clear restarts count", rst_hi - base, 0);
        ticks(1);
        chk("R11 pulse after full run", rst_hi - base, 1);
        ticks(5);
        wdt_en = 1'b0;
        ticks(2 * LIMIT);
        chk("R12 no pulse while disabled", rst_hi - base, 1);
        wdt_en = 1'b1;
        ticks(LIMIT - 1);
        chk("R12 count held at zero", rst_hi - base, 1);
        ticks(1);
        chk("R12 pulse after re-enable", rst_hi - base, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_regs();
        t_edges();
        t_latency();
        t_internal();
        t_presc_timer();
        t_overflow();
        t_wdt_basic();
        t_wdt_presc();
        t_wdt_clear_off();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule